// File: doc/BRIEF.md
# SPI Serial SRAM Device

This block is the target side of a byte-addressable serial static RAM. A host controller reaches it over a four-wire SPI link in mode 0, where the clock idles low. The host pulls the active-low select line down. It then sends one instruction byte and a three-byte address, most significant byte first, and then moves data. A write instruction stores every following byte. A read instruction returns bytes on the serial output while the host clocks in dummy bytes. In both cases the address steps by one per byte and wraps at the top of the array. Raising select ends the transfer, however many bytes it held.

All link inputs are sampled with a faster local clock. Edges of the serial clock are found inside the block, so the memory array and the decode logic sit in one synchronous domain. The serial output comes out as a data bit plus an enable. The pad at the chip edge turns the enable into a tri-state driver. The array holds 2^AW bytes. The full-size part uses AW = 17 (128 KiB). The default is kept small.

Top module: `spi_sram`

## Requirements
- R1: Instruction byte 0x02, followed by three address bytes (most significant first), writes every further complete byte to the array, starting at that address. Bits on `si` are taken MSB first on each rising `sck` edge.
- R2: Instruction byte 0x03, followed by three address bytes, returns array bytes on `so`, MSB first. Each bit changes only after a falling `sck` edge. The first bit is valid after the falling edge that follows the last address bit. `si` has no effect on the array during a read.
- R3: The address rises by one after every data byte, in both directions. It wraps from 2^AW-1 to 0.
- R4: Address bits at and above position AW are ignored.
- R5: Any other instruction value makes the rest of that selection have no effect: nothing is written and `so_oe` stays 0.
- R6: Raising `cs_n` ends the current operation. The next selection starts again with a fresh instruction byte.
- R7: A data byte cut short by `cs_n` rising is discarded and not written.
- R8: `so_oe` is 0 whenever `cs_n` is high, and whenever the selection is not in the data phase of a read.
- R9: After synchronous reset the block is idle and `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, several times the `sck` rate |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low select from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host, valid while `so_oe` is 1 |
| so_oe | output | 1 | Output enable for the tri-state pad driving `so` |

## Verification
A wrong bit counter or a wrong phase shows up at the ports within one byte. Read data comes back shifted or from the wrong location, or `so_oe` rises during a write or an ignored command. A wrong address register shows up only when a later read returns the location. That is why every write is followed by a full read-back sweep of the small array. The wrap sweep and the high-bit sweep reach the boundary addresses. A leaked partial byte or an ignored command that still writes changes one memory location. That location is read back in the very next selection.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    localparam logic [7:0] OP_WRITE   = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam int         ADDR_BYTES = 3;
    localparam int         ADDR_BITS  = 8 * ADDR_BYTES;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic       rise;
        logic       fall;
        logic       desel;
        logic       din;
    } link_t;

    function automatic logic [ADDR_BITS-1:0] push_addr_byte(
        input logic [ADDR_BITS-1:0] cur,
        input logic [7:0]           b
    );
        return {cur[ADDR_BITS-9:0], b};
    endfunction

    function automatic phase_t decode_op(input logic [7:0] op);
        return (op == OP_WRITE || op == OP_READ) ? PH_ADDR : PH_SKIP;
    endfunction

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync
    import spi_sram_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sck,
    input  logic  cs_n,
    input  logic  si,
    output link_t link
);
    logic [STAGES-1:0] sck_q, cs_q, si_q;
    logic              sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= '0;
            cs_q     <= '1;
            si_q     <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_q    <= {sck_q[STAGES-2:0], sck};
            cs_q     <= {cs_q[STAGES-2:0], cs_n};
            si_q     <= {si_q[STAGES-2:0], si};
            sck_prev <= sck_q[STAGES-1];
        end
    end

    always_comb begin
        link.rise  = sck_q[STAGES-1] & ~sck_prev;
        link.fall  = ~sck_q[STAGES-1] & sck_prev;
        link.desel = cs_q[STAGES-1];
        link.din   = si_q[STAGES-1];
    end
endmodule

// File: rtl/spi_sram_mem.sv
module spi_sram_mem #(
    parameter int AW = 10,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/spi_sram_ctrl.sv
module spi_sram_ctrl
    import spi_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  link_t         link,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    wr_data,
    output logic          so,
    output logic          so_oe
);
    phase_t                 phase;
    logic                   is_read;
    logic [2:0]             bit_idx;
    logic [6:0]             rx_sh;
    logic [1:0]             addr_idx;
    logic [ADDR_BITS-1:0]   addr;
    logic [7:0]             tx_sh;
    logic                   rd_live;
    logic [7:0]             byte_now;
    logic                   byte_done;
    logic                   load_tx;

    assign byte_now  = {rx_sh, link.din};
    assign byte_done = link.rise && (bit_idx == 3'd7);
    assign load_tx   = link.fall && (phase == PH_RDATA) && (bit_idx == 3'd0);
    assign wr_en     = byte_done && (phase == PH_WDATA) && !link.desel;
    assign wr_data   = byte_now;
    assign mem_addr  = addr[AW-1:0];
    assign so        = tx_sh[7];
    assign so_oe     = rd_live && (phase == PH_RDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_OPCODE;
            is_read  <= 1'b0;
            bit_idx  <= '0;
            rx_sh    <= '0;
            addr_idx <= '0;
            addr     <= '0;
            tx_sh    <= '0;
            rd_live  <= 1'b0;
        end else if (link.desel) begin
            phase    <= PH_OPCODE;
            bit_idx  <= '0;
            addr_idx <= '0;
            rd_live  <= 1'b0;
        end else begin
            if (link.rise) begin
                rx_sh   <= byte_now[6:0];
                bit_idx <= bit_idx + 3'd1;
            end
            if (byte_done) begin
                case (phase)
                    PH_OPCODE: begin
                        phase   <= decode_op(byte_now);
                        is_read <= (byte_now == OP_READ);
                    end
                    PH_ADDR: begin
                        addr     <= push_addr_byte(addr, byte_now);
                        addr_idx <= addr_idx + 2'd1;
                        if (addr_idx == 2'(ADDR_BYTES - 1))
                            phase <= is_read ? PH_RDATA : PH_WDATA;
                    end
                    PH_WDATA: addr <= addr + 1'b1;
                    default: ;
                endcase
            end
            if (link.fall && phase == PH_RDATA) begin
                if (load_tx) begin
                    tx_sh   <= rd_data;
                    addr    <= addr + 1'b1;
                    rd_live <= 1'b1;
                end else begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    p_oe_off_when_deselected_r8: assert property (@(posedge clk) disable iff (rst)
        link.desel |=> !so_oe);

    p_addr_steps_after_write_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (addr == $past(addr) + 1'b1));

    p_addr_steps_after_load_r3: assert property (@(posedge clk) disable iff (rst)
        load_tx && !link.desel |=> (addr == $past(addr) + 1'b1));

    p_skip_is_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) && !link.desel |=> (phase == PH_SKIP) && !wr_en);

    p_fresh_byte_after_deselect_r6: assert property (@(posedge clk) disable iff (rst)
        link.desel |=> (bit_idx == 3'd0) && (phase == PH_OPCODE));

    p_so_moves_on_fall_only_r2: assert property (@(posedge clk) disable iff (rst)
        !link.fall |=> $stable(tx_sh));
endmodule

// File: rtl/spi_sram.sv
module spi_sram
    import spi_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so,
    output logic so_oe
);
    link_t          link;
    logic           wr_en;
    logic [AW-1:0]  mem_addr;
    logic [7:0]     wr_data;
    logic [7:0]     rd_data;

    spi_sram_sync #(.STAGES(2)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .sck  (sck),
        .cs_n (cs_n),
        .si   (si),
        .link (link)
    );

    spi_sram_ctrl #(.AW(AW)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .link     (link),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .mem_addr (mem_addr),
        .wr_data  (wr_data),
        .so       (so),
        .so_oe    (so_oe)
    );

    spi_sram_mem #(.AW(AW)) i_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (mem_addr),
        .wr_data (wr_data),
        .rd_addr (mem_addr),
        .rd_data (rd_data)
    );

    p_reset_idle_r9: assert property (@(posedge clk)
        $past(rst) |-> !so_oe);
endmodule

// File: tb/test_spi_sram.sv
module test_spi_sram;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int HP    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so, so_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    spi_sram #(.AW(AW)) i_spi_sram (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic select();
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic deselect();
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(2 * HP);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            si = tx[i];
            wait_clk(HP);
            rx[i] = so;
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic send_header(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] d;
        xfer(op, d);
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    task automatic write_burst(input logic [23:0] a, input int n, input int seed);
        logic [7:0] d;
        select();
        send_header(8'h02, a);
        checks++;
        if (so_oe !== 1'b0) begin
            errors++;
            $display("FAIL R8: so_oe in write actual %b expected 0", so_oe);
        end
        for (int i = 0; i < n; i++) begin
            xfer(pat(i, seed), d);
            model[(int'(a) + i) % DEPTH] = pat(i, seed);
        end
        deselect();
    endtask

    task automatic read_check(input string req, input logic [23:0] a, input int n);
        logic [7:0] d;
        select();
        send_header(8'h03, a);
        for (int i = 0; i < n; i++) begin
            xfer(8'hA5 ^ 8'(i), d);
            chk(req, d, model[(int'(a) + i) % DEPTH]);
        end
        deselect();
    endtask

    initial begin
        logic [7:0] d;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        chk("R9 reset so_oe", {7'd0, so_oe}, 8'd0);

        // R1 R2: fill the whole array, then read it all back
        write_burst(24'h000000, DEPTH, 1);
        read_check("R1 R2 full sweep", 24'h000000, DEPTH);
        chk("R8 so_oe after deselect", {7'd0, so_oe}, 8'd0);

        // R3: write and read across the top of the array
        write_burst(24'(DEPTH - 2), 4, 2);
        read_check("R3 wrap read", 24'(DEPTH - 3), 6);

        // R4: high address bits set
        write_burst(24'hFFFFC0 | 24'd20, 3, 3);
        read_check("R4 high bits ignored", 24'd20, 3);
        read_check("R4 high bits on read", 24'h5A0000 | 24'd20, 3);

        // R5: unknown opcode followed by a write-looking sequence
        select();
        xfer(8'h55, d);
        xfer(8'h02, d);
        xfer(8'h00, d);
        xfer(8'h00, d);
        xfer(8'h05, d);
        xfer(8'hEE, d);
        chk("R5 so_oe after unknown opcode", {7'd0, so_oe}, 8'd0);
        deselect();
        read_check("R5 no write on unknown opcode", 24'd5, 1);

        // R7: one full byte then a five-bit fragment
        select();
        send_header(8'h02, 24'd30);
        xfer(8'h3C, d);
        model[30] = 8'h3C;
        xfer_bits(8'hC3, 5, d);
        deselect();
        read_check("R7 partial byte dropped", 24'd30, 2);

        // R6: end a read mid-byte, next selection decodes a new write
        select();
        send_header(8'h03, 24'd40);
        xfer_bits(8'h00, 3, d);
        deselect();
        write_burst(24'd40, 2, 4);
        read_check("R6 fresh command after deselect", 24'd40, 2);

        // R2 R3: final sweep proves dummy bytes never wrote
        read_check("R2 R3 final sweep", 24'd17, DEPTH);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule